// File: doc/BRIEF.md
# Tone Gating Controller

This block decides when a 22 kHz signalling tone is placed on the supply output of a satellite receiver front end, and produces the tone itself. It reads a tone-enable bit, an external-mode bit, a low-power bit and one logic-level data pin. Depending on the two configuration bits, the pin is either an already-formed 22 kHz square wave to be copied, or an envelope that gates an internal 22 kHz generator. Holding the envelope high gives a continuous tone.

The block outputs a tone-active gate and the square wave to be superimposed on the supply. The pin is first brought into the system clock domain through a two-flop synchroniser. Every start and stop delay is a parameter counted in system clock cycles. In external-waveform mode, activity on the pin is tracked by a retriggerable quiet-time counter. In envelope mode, the delays are counted on the level of the synchronised pin. The internal wave comes from a divider of the system clock, and its phase restarts each time the gate opens.

Top module: `tone_gate_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycles after its release, `tone_gate` and `tone_wave` are 0.
- R2: When `tone_en` is 0 or `low_power` is 1, `tone_gate` is 0 from the first clock edge that samples that condition. Pin activity during that time starts no tone. Once the block is enabled again with the pin held high in envelope mode, the gate reopens ENV_ON_CYC edges after the enabling edge.
- R3: In envelope mode (`ext_mode`=0), a pin rise held for at least ENV_ON_CYC cycles raises `tone_gate` at the ENV_ON_CYC+2 edge after the rise. A shorter pulse raises no gate.
- R4: In envelope mode, `tone_gate` falls at the ENV_OFF_CYC+2 edge after the pin falls. A return high that is seen before the count ends restarts the count, and the gate stays high.
- R5: In envelope mode, `tone_wave` is high for HALF_CYC cycles from the cycle the gate rises, then low for HALF_CYC cycles, and this repeats while the gate is high.
- R6: In external mode (`ext_mode`=1), when pin edges keep coming with a spacing of no more than EXT_OFF_CYC cycles, `tone_gate` rises at the EXT_ON_CYC+2 edge after the first pin edge.
- R7: In external mode, `tone_gate` falls at the EXT_OFF_CYC+4 edge after the last pin edge.
- R8: In external mode, while the gate is high, `tone_wave` equals the pin value two cycles earlier, which preserves the frequency and duty cycle of the pin wave.
- R9: In envelope mode with the pin held high, `tone_wave` runs without a break at period 2*HALF_CYC.
- R10: A change of `ext_mode` drops `tone_gate` at the next edge, and every delay count restarts.
- R11: `tone_wave` is 0 whenever `tone_gate` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tone_en | input | 1 | Tone enable bit |
| ext_mode | input | 1 | 1: pin carries the tone wave; 0: pin is an envelope |
| low_power | input | 1 | Low-power bit; 1 suppresses any tone |
| data_in | input | 1 | Asynchronous logic-level data pin |
| tone_gate | output | 1 | High while the tone is to be driven |
| tone_wave | output | 1 | 22 kHz square wave, gated by tone_gate |

## Verification
Each result has a fixed delay after its stimulus. An envelope gate appears ENV_ON_CYC+2 edges after the pin rise and leaves ENV_OFF_CYC+2 edges after the pin fall. An external-mode gate appears EXT_ON_CYC+2 edges after the first pin edge and leaves EXT_OFF_CYC+4 edges after the last one. Disabling and mode changes act one edge after they are applied, and the external wave trails the pin by two cycles. The bench drives every input one time unit after a rising edge and samples at the falling edge. For each cycle, the expected gate and wave are computed from these edge counts relative to the edge at which the stimulus was applied.

// File: rtl/tone_gate_pkg.sv
package tone_gate_pkg;

  typedef enum logic {
    GATE_IDLE   = 1'b0,
    GATE_ACTIVE = 1'b1
  } gate_state_e;

  typedef enum logic {
    SRC_ENVELOPE = 1'b0,
    SRC_EXTERNAL = 1'b1
  } tone_src_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tone_sync.sv
module tone_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/tone_activity.sv
module tone_activity
  import tone_gate_pkg::*;
#(
  parameter int unsigned EXT_ON_CYC  = 100,
  parameter int unsigned EXT_OFF_CYC = 6000,
  parameter int unsigned ENV_ON_CYC  = 600,
  parameter int unsigned ENV_OFF_CYC = 3000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      allowed,
  input  tone_src_e src,
  input  logic      din_s,
  output logic      gate
);

  localparam int unsigned ON_MAX = max2(EXT_ON_CYC, ENV_ON_CYC);
  localparam int ON_W  = $clog2(ON_MAX + 1);
  localparam int QW    = $clog2(EXT_OFF_CYC + 1);
  localparam int OFF_W = $clog2(ENV_OFF_CYC + 1);
  localparam logic [ON_W-1:0]  EXT_ON_LIM = ON_W'(EXT_ON_CYC - 1);
  localparam logic [ON_W-1:0]  ENV_ON_LIM = ON_W'(ENV_ON_CYC - 1);
  localparam logic [OFF_W-1:0] OFF_LIM    = OFF_W'(ENV_OFF_CYC - 1);
  localparam logic [QW-1:0]    QUIET_LOAD = QW'(EXT_OFF_CYC);

  // registers
  logic              din_q;
  logic [QW-1:0]     quiet_q;
  logic [ON_W-1:0]   on_q;
  logic [OFF_W-1:0]  off_q;
  gate_state_e       state_q;
  tone_src_e         src_q;

  // next-state values
  logic [QW-1:0]     quiet_d;
  logic [ON_W-1:0]   on_d;
  logic [OFF_W-1:0]  off_d;
  gate_state_e       state_d;

  // decode
  logic              pin_edge;
  logic              restart;
  logic              quiet_live;
  logic              req;
  logic [ON_W-1:0]   on_lim;

  always_comb begin
    pin_edge   = din_s ^ din_q;
    restart    = !allowed || (src != src_q);
    quiet_live = (quiet_q != '0);
    if (src == SRC_EXTERNAL) begin
      req    = pin_edge || quiet_live;
      on_lim = EXT_ON_LIM;
    end else begin
      req    = din_s;
      on_lim = ENV_ON_LIM;
    end
  end

  // retriggerable quiet-time counter for the external waveform
  always_comb begin
    quiet_d = quiet_q;
    if (restart) begin
      quiet_d = '0;
    end else if (pin_edge) begin
      quiet_d = QUIET_LOAD;
    end else if (quiet_live) begin
      quiet_d = quiet_q - QW'(1);
    end
  end

  // gate state machine with start and stop delay counters
  always_comb begin
    state_d = state_q;
    on_d    = on_q;
    off_d   = off_q;
    if (restart) begin
      state_d = GATE_IDLE;
      on_d    = '0;
      off_d   = '0;
    end else begin
      case (state_q)
        GATE_IDLE: begin
          off_d = '0;
          if (req) begin
            if (on_q == on_lim) begin
              state_d = GATE_ACTIVE;
              on_d    = '0;
            end else begin
              on_d = on_q + ON_W'(1);
            end
          end else begin
            on_d = '0;
          end
        end
        GATE_ACTIVE: begin
          on_d = '0;
          if (src == SRC_EXTERNAL) begin
            off_d = '0;
            if (!req) begin
              state_d = GATE_IDLE;
            end
          end else if (req) begin
            off_d = '0;
          end else if (off_q == OFF_LIM) begin
            state_d = GATE_IDLE;
            off_d   = '0;
          end else begin
            off_d = off_q + OFF_W'(1);
          end
        end
        default: begin
          state_d = GATE_IDLE;
          on_d    = '0;
          off_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_q   <= 1'b0;
      quiet_q <= '0;
      on_q    <= '0;
      off_q   <= '0;
      state_q <= GATE_IDLE;
      src_q   <= SRC_ENVELOPE;
    end else begin
      din_q   <= din_s;
      quiet_q <= quiet_d;
      on_q    <= on_d;
      off_q   <= off_d;
      state_q <= state_d;
      src_q   <= src;
    end
  end

  assign gate = (state_q == GATE_ACTIVE);

endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int unsigned HALF_CYC = 2273
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase
);

  localparam int HW = $clog2(HALF_CYC + 1);
  localparam logic [HW-1:0] HALF_LIM = HW'(HALF_CYC - 1);

  logic [HW-1:0] cnt_q;
  logic [HW-1:0] cnt_d;
  logic          phase_q;
  logic          phase_d;
  logic          wrap;

  always_comb begin
    wrap    = (cnt_q == HALF_LIM);
    cnt_d   = cnt_q;
    phase_d = phase_q;
    if (!run) begin
      // hold primed so the first half period after gate-on is high and whole
      cnt_d   = '0;
      phase_d = 1'b1;
    end else if (wrap) begin
      cnt_d   = '0;
      phase_d = ~phase_q;
    end else begin
      cnt_d = cnt_q + HW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/tone_gate_ctrl.sv
module tone_gate_ctrl
  import tone_gate_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 2273,
  parameter int unsigned EXT_ON_CYC  = 100,
  parameter int unsigned EXT_OFF_CYC = 6000,
  parameter int unsigned ENV_ON_CYC  = 600,
  parameter int unsigned ENV_OFF_CYC = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tone_en,
  input  logic ext_mode,
  input  logic low_power,
  input  logic data_in,
  output logic tone_gate,
  output logic tone_wave
);

  localparam int unsigned SYNC_STAGES = 2;

  logic      rst_sync_n;
  logic      pin_s;
  logic      allowed;
  tone_src_e src;
  logic      gate;
  logic      int_phase;
  logic      wave_src;

  // asynchronous assert, synchronous release
  tone_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  tone_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (data_in),
    .q     (pin_s)
  );

  always_comb begin
    allowed = tone_en && !low_power;
    src     = ext_mode ? SRC_EXTERNAL : SRC_ENVELOPE;
  end

  tone_activity #(
    .EXT_ON_CYC  (EXT_ON_CYC),
    .EXT_OFF_CYC (EXT_OFF_CYC),
    .ENV_ON_CYC  (ENV_ON_CYC),
    .ENV_OFF_CYC (ENV_OFF_CYC)
  ) u_activity (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .allowed (allowed),
    .src     (src),
    .din_s   (pin_s),
    .gate    (gate)
  );

  tone_divider #(.HALF_CYC(HALF_CYC)) u_divider (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (gate),
    .phase (int_phase)
  );

  always_comb begin
    wave_src  = (src == SRC_EXTERNAL) ? pin_s : int_phase;
    tone_gate = gate;
    tone_wave = gate && wave_src;
  end

endmodule

// File: rtl/tone_gate_chk.sv
module tone_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic tone_en,
  input logic ext_mode,
  input logic low_power,
  input logic data_in,
  input logic tone_gate,
  input logic tone_wave
);

  // R2: a disabling condition closes the gate at the next edge
  assert_disable_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tone_en || low_power) |=> !tone_gate);

  // R2: the gate only opens out of an enabled cycle
  assert_rise_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tone_gate) |-> ($past(tone_en) && !$past(low_power)));

  // R10: a mode change closes the gate at the next edge
  assert_mode_change_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode != $past(ext_mode)) |=> !tone_gate);

  // R5: the internal wave begins with a high half period
  assert_env_first_half_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tone_gate) && !ext_mode) |-> tone_wave);

  // R1: nothing is driven while reset is held
  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!tone_gate || $isunknown(tone_gate));
    end
  end

  logic unused_pin;
  assign unused_pin = data_in;

endmodule

bind tone_gate_ctrl tone_gate_chk u_tone_gate_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tone_en   (tone_en),
  .ext_mode  (ext_mode),
  .low_power (low_power),
  .data_in   (data_in),
  .tone_gate (tone_gate),
  .tone_wave (tone_wave)
);

// File: tb/tb_tone_gate_ctrl.sv
`timescale 1ns/1ps
module tb_tone_gate_ctrl;

  localparam int HALF    = 4;
  localparam int EXT_ON  = 3;
  localparam int EXT_OFF = 20;
  localparam int ENV_ON  = 6;
  localparam int ENV_OFF = 15;

  logic clk = 1'b0;
  logic rst_n, tone_en, ext_mode, low_power, data_in;
  logic tone_gate, tone_wave;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  tone_gate_ctrl #(
    .HALF_CYC(HALF), .EXT_ON_CYC(EXT_ON), .EXT_OFF_CYC(EXT_OFF),
    .ENV_ON_CYC(ENV_ON), .ENV_OFF_CYC(ENV_OFF)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tone_en(tone_en), .ext_mode(ext_mode),
    .low_power(low_power), .data_in(data_in),
    .tone_gate(tone_gate), .tone_wave(tone_wave)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic env_gate_exp(input int len, input int c);
    return (len >= ENV_ON) && (c >= ENV_ON + 2) && (c < len + 2 + ENV_OFF);
  endfunction

  function automatic logic env_wave_exp(input int c, input logic g);
    int k;
    if (!g) return 1'b0;
    k = c - (ENV_ON + 2);
    return (k % (2 * HALF)) < HALF;
  endfunction

  // envelope pulse of len cycles
  task automatic env_pulse(input int len, input string wtag);
    logic g;
    @(posedge clk); #1 data_in = 1'b1;
    for (int c = 1; c <= len + ENV_OFF + 8; c++) begin
      @(posedge clk); #1;
      if (c == len) data_in = 1'b0;
      @(negedge clk);
      g = env_gate_exp(len, c);
      check((c < len + 2) ? "R3" : "R4", "gate", tone_gate, g);
      check(g ? wtag : "R11", "wave", tone_wave, env_wave_exp(c, g));
    end
  endtask

  // high l1, low gap, high l2, then low (R4 restart)
  task automatic env_gap(input int l1, input int gap, input int l2);
    logic g;
    int last = l1 + gap + l2;
    @(posedge clk); #1 data_in = 1'b1;
    for (int c = 1; c <= last + ENV_OFF + 8; c++) begin
      @(posedge clk); #1;
      if (c == l1) data_in = 1'b0;
      if (c == l1 + gap) data_in = 1'b1;
      if (c == last) data_in = 1'b0;
      @(negedge clk);
      g = (c >= ENV_ON + 2) && (c < last + 2 + ENV_OFF);
      check("R4", "gate", tone_gate, g);
      check("R5", "wave", tone_wave, env_wave_exp(c, g));
    end
  endtask

  // external waveform burst: t toggles spaced h cycles
  task automatic ext_burst(input int h, input int t);
    logic hist [0:511];
    logic g, w;
    int tl = (t - 1) * h;
    @(posedge clk); #1 data_in = 1'b1;
    hist[0] = 1'b1;
    for (int c = 1; c <= tl + EXT_OFF + 8; c++) begin
      @(posedge clk); #1;
      if ((c % h == 0) && (c / h < t)) data_in = ~data_in;
      hist[c] = data_in;
      @(negedge clk);
      g = (c >= EXT_ON + 2) && (c < tl + EXT_OFF + 4);
      w = (c >= 2) ? (g & hist[c-2]) : 1'b0;
      check((c < tl + 2) ? "R6" : "R7", "gate", tone_gate, g);
      check("R8", "wave", tone_wave, w);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7771));
    rst_n = 1'b0; tone_en = 1'b0; ext_mode = 1'b0; low_power = 1'b0; data_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "gate in reset", tone_gate, 1'b0);
    check("R1", "wave in reset", tone_wave, 1'b0);
    @(posedge clk); #1 rst_n = 1'b1;
    idle(4);
    tone_en = 1'b1;
    @(negedge clk);
    check("R1", "gate after reset", tone_gate, 1'b0);
    check("R1", "wave after reset", tone_wave, 1'b0);
    idle(3);

    // envelope mode, directed boundaries
    env_pulse(ENV_ON - 1, "R5");
    env_pulse(ENV_ON, "R5");
    env_pulse(100, "R9");
    env_gap(ENV_ON + 4, ENV_OFF - 1, 3);
    env_gap(ENV_ON, 1, 1);
    for (int i = 0; i < 6; i++) env_pulse(1 + int'($urandom % (3 * ENV_ON)), "R5");

    // R2: low_power during an envelope tone, then release
    @(posedge clk); #1 data_in = 1'b1;
    for (int c = 1; c <= 60; c++) begin
      logic g;
      @(posedge clk); #1;
      if (c == 12) low_power = 1'b1;
      if (c == 20) low_power = 1'b0;
      if (c == 40) data_in = 1'b0;
      @(negedge clk);
      g = ((c >= ENV_ON + 2) && (c <= 12)) || ((c >= 20 + ENV_ON) && (c < 42 + ENV_OFF));
      check("R2", "gate", tone_gate, g);
      if (!g) check("R11", "wave", tone_wave, 1'b0);
    end
    idle(5);

    // external waveform mode
    ext_mode = 1'b1;
    idle(4);
    ext_burst(4, 6);
    ext_burst(EXT_OFF, 2);
    ext_burst(1, 8);
    for (int i = 0; i < 6; i++) ext_burst(2 + int'($urandom % 11), 2 * (1 + int'($urandom % 6)));

    // R2: pin activity while disabled, first by tone_en then by low_power
    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 0) tone_en = 1'b0; else low_power = 1'b1;
      for (int c = 1; c <= 40; c++) begin
        @(posedge clk); #1;
        if ((c % 3 == 0) && (c <= 36)) data_in = ~data_in;
        @(negedge clk);
        check("R2", "gate while disabled", tone_gate, 1'b0);
        check("R11", "wave while disabled", tone_wave, 1'b0);
      end
      tone_en = 1'b1;
      low_power = 1'b0;
      idle(EXT_OFF + 5);
      @(negedge clk);
      check("R2", "gate after quiet re-enable", tone_gate, 1'b0);
    end

    // R10: mode change while the external tone is active
    @(posedge clk); #1 data_in = 1'b1;
    for (int c = 1; c <= 30; c++) begin
      @(posedge clk); #1;
      if ((c % 4 == 0) && (c <= 28)) data_in = ~data_in;
      if (c == 20) ext_mode = 1'b0;
      @(negedge clk);
      if (c == 10) check("R6", "gate before mode change", tone_gate, 1'b1);
      if (c == 20) check("R10", "gate at mode change edge", tone_gate, 1'b1);
      if (c >= 21) check("R10", "gate after mode change", tone_gate, 1'b0);
    end
    idle(ENV_OFF + 5);
    @(negedge clk);
    check("R10", "gate settled", tone_gate, 1'b0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule